// File: doc/BRIEF.md
# Phase-Frequency Detector with Programmable Overlap Delay

This block compares two divided clocks in a phase-locked loop: a reference pulse train from the reference divider and a feedback pulse train from the loop divider. A rising edge on the reference input sets the `up` output and a rising edge on the feedback input sets the `dn` output. Each output stays high until the other input has also produced an edge. The block therefore detects frequency error as well as phase error. Both outputs drive a charge pump.

When both outputs are high, a shared clearing path waits for a programmable number of system-clock cycles and then drops both outputs in the same cycle. As a result, every comparison ends with a short window where both outputs are high, even when the phase error is zero. This minimum overlap removes the dead zone from the detector's transfer function. The overlap length is chosen by a 2-bit code, which selects 1, 2, 3 or 4 cycles. Inputs are synchronous to the system clock, and an edge is a cycle in which the input is 1 after being 0 in the previous cycle.

Top module: `pfd_abl_top`

## Requirements
- R1: While `rst_n` is low, and after its release until the first input edge, `up` and `dn` are 0. An input counts as having been 0 before the first clock after reset.
- R2: A rising edge on `ref_pulse` makes `up` 1 in the next cycle, unless that cycle is a clearing cycle. Holding `ref_pulse` high produces no further edge.
- R3: A rising edge on `fb_pulse` makes `dn` 1 in the next cycle, unless that cycle is a clearing cycle. Holding `fb_pulse` high produces no further edge.
- R4: While exactly one output is high, it stays high, and the other stays low, until an edge arrives on the other input. Repeated edges on the input that is already ahead have no effect.
- R5: Once both outputs are high, they remain high together for exactly `abl_sel + 1` cycles, with `abl_sel` read as an unsigned 2-bit code. Both then fall in the same cycle.
- R6: When edges arrive on both inputs in the same cycle, `up` and `dn` form pulses of equal width, and that width is `abl_sel + 1` cycles.
- R7: An input edge that arrives in the cycle in which both outputs are being cleared is remembered. Its output goes low for one cycle and then rises in the following cycle.
- R8: The two outputs never fall apart while overlapping: if both are high in one cycle, then in the next cycle they are either both high or both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | Divided reference pulse train |
| fb_pulse | input | 1 | Divided feedback pulse train |
| abl_sel | input | SEL_W | Overlap length code; the overlap is code + 1 cycles |
| up | output | 1 | Pump-up request, set by a reference edge |
| dn | output | 1 | Pump-down request, set by a feedback edge |

## Verification
The hardest case to reach is an input edge that lands in the single cycle in which the delayed clear fires (R7). Random stimulus hits this cycle only rarely. The bench reaches it on purpose: it applies coincident edges, counts `abl_sel + 1` overlap cycles, and raises the reference input in exactly the clearing cycle. It then checks the one-cycle gap followed by the re-raised output. A long random sweep, with the delay code changed only while both outputs are low, compares every cycle against a behavioural model.

// File: rtl/pfd_abl_pkg.sv
// Package: shared constants for the phase-frequency detector.
// Assumes two detector channels: index 0 is the reference, index 1 the feedback.
package pfd_abl_pkg;
    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;
    localparam int NUM_CH = 2;

    // Overlap length in cycles for a given selection code.
    function automatic int overlap_cycles(input int code);
        return code + 1;
    endfunction
endpackage

// File: rtl/pfd_edge_capture.sv
// Module: one detector flip-flop with rising-edge capture.
// Sets its flag on a rising edge of a synchronous pulse input. Drops the flag
// when the shared clear fires. An edge seen during the clear cycle is held
// back and applied in the following cycle.
// Assumes the clear never fires in two consecutive cycles.
module pfd_edge_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic clear_i,
    output logic flag_o
);
    logic prev_q;
    logic pend_q;
    logic flag_q;
    logic rise;

    assign rise = pulse_i & ~prev_q;

    // Remember the previous input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pulse_i;
    end

    // Hold an edge that collides with the clear cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (clear_i) pend_q <= rise;
        else              pend_q <= 1'b0;
    end

    // Detector flip-flop: set by a new or held-back edge, dropped by the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (clear_i)        flag_q <= 1'b0;
        else if (rise || pend_q) flag_q <= 1'b1;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/pfd_reset_delay.sv
// Module: delayed common clear for both detector flip-flops.
// Counts the cycles during which both flags are high. Fires the clear once
// the count reaches the selected code, giving code + 1 overlap cycles.
// Assumes the code is held stable while both flags are high.
module pfd_reset_delay #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             clear_o
);
    localparam int CNT_W = SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic             both;

    assign both    = up_i & dn_i;
    assign clear_o = both && (cnt_q >= sel_i);

    // Count the overlap cycles that have elapsed without a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (both && !clear_o) cnt_q <= cnt_q + 1'b1;
        else                      cnt_q <= '0;
    end
endmodule

// File: rtl/pfd_abl_top.sv
// Module: digital phase-frequency detector with a programmable overlap.
// A reference edge sets up and a feedback edge sets dn. Both are cleared
// together abl_sel + 1 cycles after they first overlap.
// Assumes synchronous pulse inputs and a code held stable during an overlap.
module pfd_abl_top
    import pfd_abl_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    input  logic [SEL_W-1:0] abl_sel,
    output logic             up,
    output logic             dn
);
    logic [NUM_CH-1:0] pulse_vec;
    logic [NUM_CH-1:0] flag_vec;
    logic              clear;

    assign pulse_vec[CH_REF] = ref_pulse;
    assign pulse_vec[CH_FB]  = fb_pulse;

    // One capture flip-flop per detector channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pfd_edge_capture u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse_i (pulse_vec[g]),
            .clear_i (clear),
            .flag_o  (flag_vec[g])
        );
    end

    pfd_reset_delay #(.SEL_W(SEL_W)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_i    (flag_vec[CH_REF]),
        .dn_i    (flag_vec[CH_FB]),
        .sel_i   (abl_sel),
        .clear_o (clear)
    );

    assign up = flag_vec[CH_REF];
    assign dn = flag_vec[CH_FB];
endmodule

// File: rtl/pfd_abl_checker.sv
// Module: property checker for pfd_abl_top, attached with bind.
// Keeps its own input history and overlap count, taken from the ports only.
module pfd_abl_checker #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_pulse,
    input logic             fb_pulse,
    input logic [SEL_W-1:0] abl_sel,
    input logic             up,
    input logic             dn
);
    logic ref_q;
    logic fb_q;
    int   ov_cnt;

    // Input history and the number of earlier consecutive overlap cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            fb_q   <= 1'b0;
            ov_cnt <= 0;
        end else begin
            ref_q  <= ref_pulse;
            fb_q   <= fb_pulse;
            ov_cnt <= (up && dn) ? ((ov_cnt < 8) ? ov_cnt + 1 : ov_cnt) : 0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!up && !dn));

    assert_ref_sets_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pulse && !ref_q && !(up && dn)) |=> up);

    assert_fb_sets_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_pulse && !fb_q && !(up && dn)) |=> dn);

    assert_lone_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn && !(fb_pulse && !fb_q)) |=> (up && !dn));

    assert_overlap_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |-> (ov_cnt <= int'(abl_sel)));

    assert_clear_edge_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn && ov_cnt == int'(abl_sel) && ref_pulse && !ref_q) |=> !up ##1 up);

    assert_fall_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> (up == dn));
endmodule

bind pfd_abl_top pfd_abl_checker #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .abl_sel   (abl_sel),
    .up        (up),
    .dn        (dn)
);

// File: tb/pfd_abl_top_bench.sv
// Bench: behavioural cycle model of the detector, compared on every clock.
module pfd_abl_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pulse = 1'b0;
    logic       fb_pulse = 1'b0;
    logic [1:0] abl_sel = 2'd0;
    logic       up, dn;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    running = 1'b0;
    string cur_req = "R1";

    // Model state
    int m_up = 0, m_dn = 0, m_ov = 0, m_pr = 0, m_pf = 0, m_rd = 0, m_fd = 0;

    always #2 clk = ~clk;

    pfd_abl_top u_pfd_abl_top (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .abl_sel(abl_sel), .up(up), .dn(dn)
    );

    // Reference model: advance one cycle on each rising clock edge.
    always @(posedge clk) begin
        int er, ef, fire, both;
        if (!rst_n) begin
            m_up = 0; m_dn = 0; m_ov = 0; m_pr = 0; m_pf = 0; m_rd = 0; m_fd = 0;
        end else begin
            er = (ref_pulse && m_rd == 0) ? 1 : 0;
            ef = (fb_pulse  && m_fd == 0) ? 1 : 0;
            both = (m_up == 1 && m_dn == 1) ? 1 : 0;
            fire = (both == 1 && m_ov >= int'(abl_sel)) ? 1 : 0;
            if (fire == 1) begin
                m_up = 0; m_dn = 0; m_ov = 0; m_pr = er; m_pf = ef;
            end else begin
                if (er == 1 || m_pr == 1) m_up = 1;
                if (ef == 1 || m_pf == 1) m_dn = 1;
                m_pr = 0; m_pf = 0;
                m_ov = (both == 1) ? m_ov + 1 : 0;
            end
            m_rd = ref_pulse ? 1 : 0;
            m_fd = fb_pulse ? 1 : 0;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            check(cur_req, int'(up), m_up, "up vs model");
            check(cur_req, int'(dn), m_dn, "dn vs model");
        end
    end

    task automatic drv(input bit r, input bit f);
        @(negedge clk);
        ref_pulse = r;
        fb_pulse  = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        running = 1'b1;
        cur_req = "R1";
        idle(3);
        check("R1", int'(up), 0, "up in reset");
        check("R1", int'(dn), 0, "dn in reset");
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        check("R1", int'(up) + int'(dn), 0, "outputs idle after reset");

        // R6: coincident edges give equal pulses of sel+1 cycles
        cur_req = "R6";
        for (int s = 0; s < 4; s++) begin
            int wu, wd;
            abl_sel = 2'(s);
            drv(1'b1, 1'b1);
            wu = 0; wd = 0;
            for (int i = 0; i < 10; i++) begin
                drv(1'b0, 1'b0);
                if (up) wu++;
                if (dn) wd++;
            end
            check("R6", wu, s + 1, "up width coincident");
            check("R6", wd, s + 1, "dn width coincident");
        end

        // R5, R2: reference leads by 3 cycles
        cur_req = "R5";
        for (int s = 0; s < 4; s++) begin
            int wu, wd;
            abl_sel = 2'(s);
            drv(1'b1, 1'b0);
            wu = 0; wd = 0;
            for (int i = 0; i < 14; i++) begin
                drv(1'b0, (i == 2) ? 1'b1 : 1'b0);
                if (up) wu++;
                if (dn) wd++;
            end
            check("R5", wu, 3 + s + 1, "up width with lead");
            check("R5", wd, s + 1, "dn overlap width");
        end

        // R4, R3: feedback alone with repeated edges holds dn, up stays low
        cur_req = "R4";
        abl_sel = 2'd1;
        drv(1'b0, 1'b1);
        drv(1'b0, 1'b0);
        check("R3", int'(dn), 1, "dn set by feedback edge");
        for (int i = 0; i < 6; i++) drv(1'b0, i[0]);
        check("R4", int'(dn), 1, "dn held without reference");
        check("R4", int'(up), 0, "up low without reference");
        drv(1'b1, 1'b0);
        idle(6);
        check("R4", int'(up) + int'(dn), 0, "cleared after reference edge");

        // R2: held reference level triggers once only
        cur_req = "R2";
        drv(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) drv(1'b1, (i == 1) ? 1'b1 : 1'b0);
        for (int i = 0; i < 6; i++) drv(1'b1, 1'b0);
        check("R2", int'(up), 0, "no retrigger from held level");

        idle(2);
        // R7: reference edge in the clear cycle is kept
        cur_req = "R7";
        abl_sel = 2'd1;
        drv(1'b1, 1'b1);
        drv(1'b0, 1'b0);
        drv(1'b1, 1'b0);
        drv(1'b1, 1'b0);
        check("R7", int'(up), 0, "up low in cycle after clear");
        drv(1'b1, 1'b0);
        check("R7", int'(up), 1, "up raised by held-back edge");
        check("R8", int'(dn), 0, "dn stays low after clear");
        drv(1'b0, 1'b1);
        idle(6);

        // Random sweep against the model; code changes only when idle
        cur_req = "R8";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (m_up == 0 && m_dn == 0 && ($urandom % 8) == 0) abl_sel = 2'($urandom);
            ref_pulse = (($urandom % 4) == 0);
            fb_pulse  = (($urandom % 4) == 0);
        end
        idle(8);
        finish_run();
    end
endmodule